// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of an integrating analog-to-digital converter. A prescaler turns the fast oscillator clock into a slower count clock. Every conversion has the same length in counts, whatever the input. Each conversion runs in this order:

- a signal-integrate phase of fixed length;
- a reference de-integrate phase, which ends when the comparator reports that the integrator has crossed back through zero;
- an auto-zero phase, which takes up whatever time the de-integrate phase did not use.

The block drives one enable for each analog switch group: auto-zero, integrate, de-integrate with the positive reference, and de-integrate with the negative reference. A one-count break with every switch open separates any two phases.

The comparator output enters through a multi-flop synchronizer. The synchronized level is sampled when signal integration ends, and that sample fixes both the reading's sign and the reference polarity used for de-integration. The de-integrate phase is timed by a BCD decade counter. In a single clock, the block copies either that count or an overrange indication into the output latch, together with the sign. The integrator and the comparator are analog and lie outside the block.

Top module: `dslope_seq`

## Requirements
- R1: Every phase boundary and every count falls on a count tick, which occurs once every PRESCALE oscillator clocks; each all-open break therefore lasts exactly PRESCALE oscillator clocks.
- R2: The integrate switch is closed for exactly SIG_COUNTS counts per conversion.
- R3: During de-integrate, counts are evaluated one per tick starting from 0. At the first evaluation where the synchronized comparator differs from the level sampled at the end of integration, the current count value n becomes the reading, and the phase has lasted n+1 counts.
- R4: If DEINT_MAX evaluations pass without a crossing, de-integrate ends after DEINT_MAX counts, the overrange flag is set and the latched digits are all zero; otherwise the overrange flag is cleared.
- R5: A conversion is always CYCLE_COUNTS counts long. Auto-zero lasts CYCLE_COUNTS − SIG_COUNTS − d − 3 counts, where d is the de-integrate length. The parameters must satisfy CYCLE_COUNTS ≥ SIG_COUNTS + DEINT_MAX + 4.
- R6: If the sampled comparator level is high (input positive), de-integrate closes the negative-reference switch and the latched sign output is 0. If the level is low, the positive-reference switch closes and the sign output is 1.
- R7: The reading is presented as packed BCD, with units in bits [3:0], tens in [7:4], hundreds in [11:8] and so on. A full-scale reading is DEINT_MAX−1.
- R8: The digits, sign and overrange outputs change only in the single clock at the end of de-integrate, and hold steady at every other time.
- R9: The comparator is used only after SYNC_STAGES oscillator-clock flops, so a change on it can only influence a decision made at least that many clocks later.
- R10: At most one switch group is closed at any time. Between any two phases there is a break of one count in which every switch is open.
- R11: In reset the auto-zero switch is closed and all other switches are open; digits, sign and overrange read zero. The first integrate phase starts after a full auto-zero period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Comparator output, asynchronous; high when the integrator output is positive |
| sw_az_o | output | 1 | Auto-zero switch enable |
| sw_int_o | output | 1 | Signal-integrate switch enable |
| sw_depos_o | output | 1 | De-integrate enable using the positive reference |
| sw_deneg_o | output | 1 | De-integrate enable using the negative reference |
| digits_o | output | 4*DIGITS | Latched reading in packed BCD |
| neg_o | output | 1 | Latched sign, 1 for a negative input |
| ovr_o | output | 1 | Latched overrange flag |

## Verification
The bench builds the block with PRESCALE=3, SIG_COUNTS=10, DEINT_MAX=20, CYCLE_COUNTS=40 and four digits. One conversion then takes 120 oscillator clocks, so dozens of conversions fit in a short run. With these values every reading from 0 up to full scale and past overrange can be reached, and a two-digit carry chain is exercised. An odd prescale ratio also makes the synchronizer latency show up as an exact count offset if it is wrong.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

  typedef enum logic [2:0] {
    PH_AZ   = 3'd0,
    PH_GAP3 = 3'd1,
    PH_INT  = 3'd2,
    PH_GAP1 = 3'd3,
    PH_DE   = 3'd4,
    PH_GAP2 = 3'd5
  } phase_t;

  // binary value -> packed BCD, nd digits (nd <= 8)
  function automatic logic [31:0] to_bcd(input int unsigned v, input int nd);
    logic [31:0] r;
    int unsigned x;
    r = '0;
    x = v;
    for (int i = 0; i < 8; i++) begin
      if (i < nd) begin
        r[4*i +: 4] = 4'(x % 10);
        x = x / 10;
      end
    end
    return r;
  endfunction

  // packed BCD -> binary value, nd digits (nd <= 8)
  function automatic int unsigned bcd_value(input logic [31:0] b, input int nd);
    int unsigned r;
    r = 0;
    for (int i = 7; i >= 0; i--) begin
      if (i < nd) r = r * 10 + int'(b[4*i +: 4]);
    end
    return r;
  endfunction

endpackage

// File: rtl/dslope_presc.sv
module dslope_presc #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (DIV > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o) else $error("tick spacing");  // R1
    end
  endgenerate

endmodule

// File: rtl/dslope_sync.sv
module dslope_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sh_q[0] <= 1'b0;
          else         sh_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sh_q[i] <= 1'b0;
          else         sh_q[i] <= sh_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/dslope_bcd_cnt.sv
module dslope_bcd_cnt #(
  parameter int unsigned DIGITS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  inc_i,
  output logic [4*DIGITS-1:0]   cnt_o
);
  logic [DIGITS:0] carry;
  assign carry[0] = inc_i;

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_dec
      logic [3:0] dig_q;
      assign carry[i+1] = carry[i] && (dig_q == 4'd9);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       dig_q <= 4'd0;
        else if (clr_i)    dig_q <= 4'd0;
        else if (carry[i]) dig_q <= (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
      end
      assign cnt_o[4*i +: 4] = dig_q;

      AST_DIGIT_DECIMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dig_q <= 4'd9) else $error("digit out of range");  // R7
    end
  endgenerate

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int unsigned PRESCALE     = 4,
  parameter int unsigned SIG_COUNTS   = 1000,
  parameter int unsigned DEINT_MAX    = 2000,
  parameter int unsigned CYCLE_COUNTS = 4000,
  parameter int unsigned DIGITS       = 4,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic                clk_osc_i,
  input  logic                rst_ni,
  input  logic                cmp_i,
  output logic                sw_az_o,
  output logic                sw_int_o,
  output logic                sw_depos_o,
  output logic                sw_deneg_o,
  output logic [4*DIGITS-1:0] digits_o,
  output logic                neg_o,
  output logic                ovr_o
);
  localparam int unsigned CYC_W = $clog2(CYCLE_COUNTS);
  localparam int unsigned DW    = 4 * DIGITS;
  localparam logic [CYC_W-1:0] INT_LAST = CYC_W'(SIG_COUNTS - 1);
  localparam logic [CYC_W-1:0] AZ_LAST  = CYC_W'(CYCLE_COUNTS - 2);
  localparam logic [CYC_W-1:0] CYC_END  = CYC_W'(CYCLE_COUNTS - 1);
  localparam logic [31:0]      DE_LAST_W = to_bcd(DEINT_MAX - 1, DIGITS);
  localparam logic [DW-1:0]    DE_LAST   = DE_LAST_W[DW-1:0];

  // ---------------- timebase and synchronizer
  logic tick;
  logic cmp_s;

  dslope_presc #(.DIV(PRESCALE)) presc_i (
    .clk_i (clk_osc_i), .rst_ni (rst_ni), .tick_o (tick)
  );

  dslope_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_osc_i), .rst_ni (rst_ni), .d_i (cmp_i), .q_o (cmp_s)
  );

  // ---------------- cycle position counter
  logic [CYC_W-1:0] cyc_q;

  always_ff @(posedge clk_osc_i or negedge rst_ni) begin
    if (!rst_ni)              cyc_q <= '0;
    else if (tick) cyc_q <= (cyc_q == CYC_END) ? '0 : cyc_q + 1'b1;
  end

  // ---------------- phase state
  phase_t st_q, st_d;
  logic   pol_q;     // comparator level sampled at end of integrate
  logic [DW-1:0] cnt;

  // named internal events
  logic int_done, de_cross, de_full, de_done, az_done;
  assign int_done = tick && (st_q == PH_INT) && (cyc_q == INT_LAST);
  assign de_cross = tick && (st_q == PH_DE) && (cmp_s != pol_q);
  assign de_full  = tick && (st_q == PH_DE) && !de_cross && (cnt == DE_LAST);
  assign de_done  = de_cross || de_full;
  assign az_done  = tick && (st_q == PH_AZ) && (cyc_q == AZ_LAST);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PH_AZ:   if (az_done)  st_d = PH_GAP3;
      PH_GAP3: if (tick)     st_d = PH_INT;
      PH_INT:  if (int_done) st_d = PH_GAP1;
      PH_GAP1: if (tick)     st_d = PH_DE;
      PH_DE:   if (de_done)  st_d = PH_GAP2;
      PH_GAP2: if (tick)     st_d = PH_AZ;
      default:               st_d = PH_AZ;
    endcase
  end

  always_ff @(posedge clk_osc_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= PH_AZ;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk_osc_i or negedge rst_ni) begin
    if (!rst_ni)       pol_q <= 1'b0;
    else if (int_done) pol_q <= cmp_s;
  end

  // ---------------- de-integrate decade counter
  logic cnt_clr, cnt_inc;
  assign cnt_clr = (st_q == PH_GAP1);
  assign cnt_inc = tick && (st_q == PH_DE) && !de_done;

  dslope_bcd_cnt #(.DIGITS(DIGITS)) cnt_i (
    .clk_i (clk_osc_i), .rst_ni (rst_ni),
    .clr_i (cnt_clr), .inc_i (cnt_inc), .cnt_o (cnt)
  );

  // ---------------- output latch, one-cycle transfer
  always_ff @(posedge clk_osc_i or negedge rst_ni) begin
    if (!rst_ni) begin
      digits_o <= '0;
      neg_o    <= 1'b0;
      ovr_o    <= 1'b0;
    end else if (de_done) begin
      digits_o <= de_cross ? cnt : '0;
      neg_o    <= !pol_q;
      ovr_o    <= de_full;
    end
  end

  // ---------------- switch decode
  assign sw_az_o    = (st_q == PH_AZ);
  assign sw_int_o   = (st_q == PH_INT);
  assign sw_depos_o = (st_q == PH_DE) && !pol_q;
  assign sw_deneg_o = (st_q == PH_DE) &&  pol_q;

  // ---------------- assertions
  AST_INT_BOUND: assert property (@(posedge clk_osc_i) disable iff (!rst_ni)
    sw_int_o |-> (cyc_q <= INT_LAST)) else $error("integrate overrun");  // R2

  AST_INT_START: assert property (@(posedge clk_osc_i) disable iff (!rst_ni)
    $rose(sw_int_o) |-> (cyc_q == '0)) else $error("cycle misaligned");  // R5

  AST_DE_BOUND: assert property (@(posedge clk_osc_i) disable iff (!rst_ni)
    (st_q == PH_DE) |-> (bcd_value(32'(cnt), DIGITS) < DEINT_MAX)) else $error("de overrun");  // R4

  AST_OVR_ZERO: assert property (@(posedge clk_osc_i) disable iff (!rst_ni)
    ovr_o |-> (digits_o == '0)) else $error("overrange digits");  // R4

  AST_LATCH_HOLD: assert property (@(posedge clk_osc_i) disable iff (!rst_ni)
    !de_done |=> ($stable(digits_o) && $stable(neg_o) && $stable(ovr_o))) else $error("latch moved");  // R8

  AST_BREAK_DE: assert property (@(posedge clk_osc_i) disable iff (!rst_ni)
    $rose(sw_depos_o || sw_deneg_o) |-> $past(!sw_int_o && !sw_az_o)) else $error("no break before de");  // R10

  AST_BREAK_INT: assert property (@(posedge clk_osc_i) disable iff (!rst_ni)
    $rose(sw_int_o) |-> $past(!sw_az_o)) else $error("no break before int");  // R10

  AST_ONE_GROUP: assert property (@(posedge clk_osc_i) disable iff (!rst_ni)
    $onehot0({sw_az_o, sw_int_o, sw_depos_o, sw_deneg_o})) else $error("switch overlap");  // R10

endmodule

// File: tb/dslope_seq_tb.sv
module dslope_seq_tb_top;
  localparam int P    = 3;
  localparam int SIG  = 10;
  localparam int DMAX = 20;
  localparam int CYC  = 40;
  localparam int ND   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp = 1'b0;
  logic sw_az, sw_int, sw_depos, sw_deneg, neg, ovr;
  logic [4*ND-1:0] digits;

  always #2.5 clk = ~clk;

  dslope_seq #(
    .PRESCALE(P), .SIG_COUNTS(SIG), .DEINT_MAX(DMAX),
    .CYCLE_COUNTS(CYC), .DIGITS(ND), .SYNC_STAGES(2)
  ) dut_i (
    .clk_osc_i(clk), .rst_ni(rst_n), .cmp_i(cmp),
    .sw_az_o(sw_az), .sw_int_o(sw_int), .sw_depos_o(sw_depos), .sw_deneg_o(sw_deneg),
    .digits_o(digits), .neg_o(neg), .ovr_o(ovr)
  );

  int n_chk = 0;
  int n_fail = 0;
  int overlap = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int bcd_of(input int v);
    int r = 0;
    int x = v;
    for (int i = 0; i < ND; i++) begin
      r = r | ((x % 10) << (4 * i));
      x = x / 10;
    end
    return r;
  endfunction

  function automatic int de_len(input int m);
    return (m >= DMAX) ? DMAX : m + 1;
  endfunction

  task automatic step();
    @(negedge clk);
    if ($countones({sw_az, sw_int, sw_depos, sw_deneg}) > 1) overlap++;
  endtask

  // one conversion: sign pos, crossing after m counts (m >= DMAX: none)
  task automatic conv(input bit pos, input int m);
    int n_int = 0, g1 = 0, n_de = 0, g2 = 0, n_az = 0, g3 = 0;
    int prev_dig, thr, d;
    bit right_sw, held = 1'b1, az_hold = 1'b1, ovr_exp;
    int az_dig;
    cmp = pos;
    while (!sw_int) step();
    prev_dig = int'(digits);
    while (sw_int) begin n_int++; step(); end
    while (!(sw_depos || sw_deneg)) begin g1++; step(); end
    right_sw = pos ? (sw_deneg && !sw_depos) : (sw_depos && !sw_deneg);
    thr = (m * P < 1) ? 1 : m * P;
    while (sw_depos || sw_deneg) begin
      n_de++;
      if (int'(digits) != prev_dig) held = 1'b0;
      if (m < DMAX && n_de >= thr) cmp = !pos;
      step();
    end
    while (!sw_az) begin g2++; step(); end
    ovr_exp = (m >= DMAX);
    d = de_len(m);
    check(int'(digits) == (ovr_exp ? 0 : bcd_of(m)), "R3 R7 R9", "reading",
          int'(digits), ovr_exp ? 0 : bcd_of(m));
    check(ovr == ovr_exp, "R4", "overrange flag", int'(ovr), int'(ovr_exp));
    check(neg == !pos, "R6", "sign", int'(neg), int'(!pos));
    az_dig = int'(digits);
    while (sw_az) begin
      n_az++;
      if (int'(digits) != az_dig) az_hold = 1'b0;
      step();
    end
    while (!sw_int) begin g3++; step(); end
    check(n_int == SIG * P, "R2", "integrate clocks", n_int, SIG * P);
    check(g1 == P && g2 == P && g3 == P, "R1 R10", "break clocks", g1 + g2 + g3, 3 * P);
    check(right_sw, "R6", "reference switch", int'(sw_deneg), int'(pos));
    check(n_de == d * P, ovr_exp ? "R4" : "R3", "de-integrate clocks", n_de, d * P);
    check(n_az == (CYC - SIG - d - 3) * P, "R5", "auto-zero clocks", n_az, (CYC - SIG - d - 3) * P);
    check(n_int + g1 + n_de + g2 + n_az + g3 == CYC * P, "R5", "cycle clocks",
          n_int + g1 + n_de + g2 + n_az + g3, CYC * P);
    check(held && az_hold, "R8", "latch stable outside update", 0, 1);
    check(overlap == 0, "R10", "switch overlap events", overlap, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int az_run;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    // R11 reset state
    check(sw_az && !sw_int && !sw_depos && !sw_deneg, "R11", "reset switches",
          int'({sw_az, sw_int, sw_depos, sw_deneg}), 8);
    check(digits == '0 && !neg && !ovr, "R11", "reset latch", int'(digits), 0);
    rst_n = 1'b1;
    // R11 first integrate after a full auto-zero period
    az_run = 0;
    while (!sw_int) begin az_run++; step(); end
    check(az_run >= (CYC - 1) * P && az_run <= CYC * P + 1, "R11", "first auto-zero clocks",
          az_run, CYC * P);
    // directed corners
    conv(1'b1, 0);
    conv(1'b0, 0);
    conv(1'b1, DMAX - 1);
    conv(1'b0, DMAX - 1);
    conv(1'b1, DMAX);
    conv(1'b0, DMAX + 7);
    conv(1'b1, 9);
    conv(1'b0, 10);
    conv(1'b1, 13);
    // random
    for (int k = 0; k < 30; k++) begin
      conv(1'($urandom_range(0, 1)), int'($urandom_range(0, DMAX + 3)));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule